// File: doc/BRIEF.md
# 8-bit Waveform Timer

This block is an 8-bit counter that advances on a selectable divided clock and produces one waveform output and two event flags. It runs in one of four modes: free counting, counting that restarts at a compare value, single-slope PWM and dual-slope PWM. In the PWM modes the compare value is double-buffered, so a write takes effect only at a safe point in the period and no glitch appears on the output.

A simple synchronous port gives access to four registers: control, counter, compare and flags. Writes take effect on the clock edge. Reads are combinational. A free-running divider inside the block supplies the count ticks. A pulse on either acknowledge input clears the matching flag, so an interrupt controller can use the flags directly.

Top module: `wave_timer8`

## Requirements
- R1: After reset, every register reads 0, and `wave_out`, `ovf_flag` and `cmp_flag` are 0.
- R2: Register addresses are 0 control, 1 counter, 2 compare and 3 flags. Control bits are [2:0] clock select, [4:3] output action, [6:5] mode (00 free, 01 dual-slope PWM, 10 clear-on-compare, 11 single-slope PWM) and [7] force strobe, which always reads 0. In the flags register, bit 0 is overflow and bit 1 is compare.
- R3: Clock select 0 stops the counter. Values 1 to 7 advance it once every 1, 8, 32, 64, 128, 256 or 1024 clocks.
- R4: In free mode the counter steps up by one per tick and wraps from 255 to 0. The overflow flag sets on the tick that leaves 255.
- R5: In clear-on-compare mode the counter returns to 0 on the tick that leaves a value equal to the compare register. The compare flag sets on every such match. In both non-PWM modes a compare write is used at once.
- R6: In non-PWM modes, output action 00 holds `wave_out` at 0. Action 01 toggles on a match, 10 drives it low and 11 drives it high.
- R7: In a non-PWM mode, a control write with bit 7 set applies the written output action at once. It sets no flag and leaves the counter unchanged. In a PWM mode the strobe has no effect.
- R8: A counter write overrides the count in its own cycle. It also cancels the match on the next tick: no flag, no output action and no restart.
- R9: Single-slope PWM counts 0 to 255. Action 10 drives low on a match and high at the wrap, giving ocr+1 high ticks per 256. Action 11 is the inverse, giving 255-ocr high ticks. Actions 00 and 01 hold the output at 0. When compare is 255, the match is ignored and only the wrap action applies.
- R10: In single-slope PWM, a compare write reads back at once but steers the output only from the next wrap.
- R11: Dual-slope PWM steps up from 0 to 255, then down to 0, one step per tick. The overflow flag sets on the tick that leaves 0 while turning upward. A buffered compare value is taken on the tick that leaves 255.
- R12: In dual-slope PWM, action 10 drives low on a match while rising and high on a match while falling. A match at 0 counts as rising. Action 11 is the inverse. A high duty is 2*ocr ticks per 510, and 510-2*ocr for the inverse. When compare is 255, the match is ignored and the falling-side level is applied on the tick that leaves 255.
- R13: Writing 1 to a flag bit clears it, and an acknowledge pulse clears its flag. A flag event in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data |
| irq_ack_ovf | input | 1 | Pulse that clears the overflow flag |
| irq_ack_cmp | input | 1 | Pulse that clears the compare flag |
| wave_out | output | 1 | Waveform output |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare-match flag |

## Verification
Some properties assume conditions on the inputs. The acknowledge-clear and force-strobe properties assume no count tick lands in the same cycle. The counter-write properties assume the write itself is the only thing that moves the count. The stimulus meets these assumptions: it stops the counter (clock select 0) before every counter write, flag clear or strobe, then restarts it with a control write. This makes every expected count a plain function of the number of edges since that restart. Duty figures are measured over whole periods after one settling period, so they do not depend on the phase.

// File: rtl/wave_timer8.sv
module wave_timer8 #(
  parameter int W  = 8,
  parameter int PW = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic         irq_ack_ovf,
  input  logic         irq_ack_cmp,
  output logic         wave_out,
  output logic         ovf_flag,
  output logic         cmp_flag
);
  localparam logic [W-1:0] MAXV   = '1;
  localparam logic [1:0]   M_NORM = 2'b00;
  localparam logic [1:0]   M_PC   = 2'b01;
  localparam logic [1:0]   M_CTC  = 2'b10;
  localparam logic [1:0]   M_FAST = 2'b11;

  logic [PW-1:0] presc_q;
  logic [1:0]    mode_q, com_q;
  logic [2:0]    cs_q;
  logic [W-1:0]  cnt_q, cnt_n, ocr_buf, ocr_act;
  logic          dir_dn, blk_q, oc_q, oc_n, ovf_q, cmp_q;
  logic [3:0]    sh;
  logic [PW-1:0] pmask;

  wire wr_ctrl = wr_en && addr == 2'd0;
  wire wr_cnt  = wr_en && addr == 2'd1;
  wire wr_ocr  = wr_en && addr == 2'd2;
  wire wr_flg  = wr_en && addr == 2'd3;

  always_comb begin
    case (cs_q)
      3'd2:    sh = 4'd3;
      3'd3:    sh = 4'd5;
      3'd4:    sh = 4'd6;
      3'd5:    sh = 4'd7;
      3'd6:    sh = 4'd8;
      3'd7:    sh = 4'd10;
      default: sh = 4'd0;
    endcase
    pmask = PW'((32'd1 << sh) - 32'd1);
  end

  wire tick     = (cs_q != 3'd0) && ((presc_q & pmask) == pmask);
  wire step     = tick && !wr_cnt;
  wire pwm      = mode_q[0];
  wire hit      = step && !blk_q && cnt_q == ocr_act;
  wire ign      = com_q[1] && ocr_act == MAXV;
  wire up_step  = dir_dn ? (cnt_q == '0) : (cnt_q != MAXV);
  wire pc_top   = step && mode_q == M_PC && !dir_dn && cnt_q == MAXV;
  wire fast_bot = step && mode_q == M_FAST && cnt_q == MAXV;
  wire ocr_upd  = (mode_q == M_PC) ? pc_top : fast_bot;
  wire ovf_ev   = step && ((mode_q == M_PC) ? (dir_dn && cnt_q == '0) : (cnt_q == MAXV));
  wire force_ev = wr_ctrl && wr_data[7] && !wr_data[5];
  wire clr_ovf  = (wr_flg && wr_data[0]) || irq_ack_ovf;
  wire clr_cmp  = (wr_flg && wr_data[1]) || irq_ack_cmp;
  wire conn     = pwm ? com_q[1] : (com_q != 2'b00);

  always_comb begin
    case (mode_q)
      M_PC: begin
        if (!dir_dn) cnt_n = (cnt_q == MAXV) ? cnt_q - 1'b1 : cnt_q + 1'b1;
        else         cnt_n = (cnt_q == '0)   ? cnt_q + 1'b1 : cnt_q - 1'b1;
      end
      M_CTC:   cnt_n = (cnt_q == ocr_act && !blk_q) ? '0 : cnt_q + 1'b1;
      default: cnt_n = cnt_q + 1'b1;
    endcase
  end

  always_comb begin
    oc_n = oc_q;
    case (mode_q)
      M_NORM, M_CTC: begin
        if (hit) begin
          case (com_q)
            2'b01:   oc_n = ~oc_q;
            2'b10:   oc_n = 1'b0;
            2'b11:   oc_n = 1'b1;
            default: oc_n = oc_q;
          endcase
        end
      end
      M_FAST: begin
        if (com_q[1]) begin
          if (hit && !ign) oc_n = com_q[0];
          if (fast_bot)    oc_n = ~com_q[0];
        end
      end
      default: begin
        if (com_q[1]) begin
          if (hit && !ign)                oc_n = up_step ? com_q[0] : ~com_q[0];
          if (pc_top && ocr_act == MAXV)  oc_n = ~com_q[0];
        end
      end
    endcase
    if (force_ev) begin
      case (wr_data[4:3])
        2'b01:   oc_n = ~oc_q;
        2'b10:   oc_n = 1'b0;
        2'b11:   oc_n = 1'b1;
        default: oc_n = oc_n;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      mode_q  <= M_NORM;
      com_q   <= 2'b00;
      cs_q    <= 3'd0;
      cnt_q   <= '0;
      ocr_buf <= '0;
      ocr_act <= '0;
      dir_dn  <= 1'b0;
      blk_q   <= 1'b0;
      oc_q    <= 1'b0;
      ovf_q   <= 1'b0;
      cmp_q   <= 1'b0;
    end else begin
      presc_q <= presc_q + PW'(1);
      if (wr_ctrl) begin
        mode_q <= wr_data[6:5];
        com_q  <= wr_data[4:3];
        cs_q   <= wr_data[2:0];
      end
      if (wr_ocr) ocr_buf <= wr_data;
      if (!pwm)         ocr_act <= wr_ocr ? wr_data : ocr_buf;
      else if (ocr_upd) ocr_act <= ocr_buf;
      if (wr_cnt)    cnt_q <= wr_data;
      else if (tick) cnt_q <= cnt_n;
      if (wr_cnt)    blk_q <= 1'b1;
      else if (tick) blk_q <= 1'b0;
      if (mode_q != M_PC)                   dir_dn <= 1'b0;
      else if (step && !dir_dn && cnt_q == MAXV) dir_dn <= 1'b1;
      else if (step && dir_dn && cnt_q == '0)    dir_dn <= 1'b0;
      oc_q  <= oc_n;
      ovf_q <= ovf_ev | (ovf_q & ~clr_ovf);
      cmp_q <= hit | (cmp_q & ~clr_cmp);
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rd_data = W'({1'b0, mode_q, com_q, cs_q});
      2'd1:    rd_data = cnt_q;
      2'd2:    rd_data = ocr_buf;
      default: rd_data = W'({cmp_q, ovf_q});
    endcase
  end

  assign wave_out = conn & oc_q;
  assign ovf_flag = ovf_q;
  assign cmp_flag = cmp_q;
endmodule

// File: rtl/wave_timer8_chk.sv
module wave_timer8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   addr,
  input logic         force_bit,
  input logic         irq_ack_ovf,
  input logic         ovf_flag,
  input logic         cmp_flag,
  input logic         tick,
  input logic         wr_cnt,
  input logic         blk_q,
  input logic [2:0]   cs_q,
  input logic [1:0]   mode_q,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] ocr_act
);
  localparam logic [W-1:0] MAXV = '1;

  assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q == 3'd0 && !wr_cnt) |=> $stable(cnt_q));

  assert_ctc_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b10 && tick && !wr_cnt && !blk_q && cnt_q == ocr_act) |=> cnt_q == '0);

  assert_forcestrobe_noflag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && force_bit && !cmp_flag && !tick) |=> !cmp_flag);

  assert_blocked_norestart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b10 && tick && !wr_cnt && blk_q && cnt_q == ocr_act && ocr_act != MAXV)
      |=> cnt_q != '0);

  assert_fast_buffer_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b11 && !(tick && cnt_q == MAXV)) |=> $stable(ocr_act));

  assert_dual_slope_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01 && tick && !wr_cnt)
      |=> (W'(cnt_q - $past(cnt_q)) == W'(1)) || (W'($past(cnt_q) - cnt_q) == W'(1)));

  assert_ack_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_ovf && !tick) |=> !ovf_flag);
endmodule

bind wave_timer8 wave_timer8_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .force_bit(wr_data[7]),
  .irq_ack_ovf(irq_ack_ovf), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag),
  .tick(tick), .wr_cnt(wr_cnt), .blk_q(blk_q), .cs_q(cs_q), .mode_q(mode_q),
  .cnt_q(cnt_q), .ocr_act(ocr_act)
);

// File: tb/wave_timer8_tb.sv
module wave_timer8_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       ack_o = 1'b0, ack_c = 1'b0;
  logic       wave, ovf, cmp;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_timer8 u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq_ack_ovf(ack_o), .irq_ack_cmp(ack_c),
    .wave_out(wave), .ovf_flag(ovf), .cmp_flag(cmp)
  );

  function automatic logic [7:0] ctl(int md, int com, int cs, int frc);
    return {frc[0], md[1:0], com[1:0], cs[2:0]};
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v, v0;
    int n, h;
    int divs[8] = '{0, 1, 8, 32, 64, 128, 256, 1024};
    int ctcs[5] = '{1, 2, 3, 7, 100};
    int fval[6] = '{0, 1, 64, 128, 254, 255};
    int pval[6] = '{0, 1, 2, 100, 254, 255};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check("R1 reset register", v, 0);
    end
    check("R1 reset outputs", {wave, ovf, cmp}, 0);

    for (int cs = 1; cs < 8; cs++) begin
      wr(2'd0, ctl(0, 0, cs, 0));
      rd(2'd1, v0);
      n = 0;
      do begin step(1); rd(2'd1, v); n++; end while (v == v0 && n < 3000);
      v0 = v; n = 0;
      do begin step(1); rd(2'd1, v); n++; end while (v == v0 && n < 3000);
      check($sformatf("R3 tick spacing cs=%0d", cs), n, divs[cs]);
    end
    wr(2'd0, ctl(0, 0, 0, 0));
    rd(2'd1, v0); step(40); rd(2'd1, v);
    check("R3 stopped counter", v, v0);

    wr(2'd3, 8'h03); wr(2'd1, 8'hFD); wr(2'd0, ctl(0, 0, 1, 0));
    step(2); rd(2'd1, v);
    check("R4 count before wrap", v, 8'hFF);
    check("R4 no overflow yet", ovf, 0);
    step(1); rd(2'd1, v);
    check("R4 wrap to zero", v, 0);
    check("R4 overflow set", ovf, 1);
    wr(2'd0, ctl(0, 0, 0, 0));
    @(negedge clk) ack_o = 1'b1;
    @(negedge clk) ack_o = 1'b0;
    check("R13 ack clears overflow", ovf, 0);

    wr(2'd2, 8'h10); wr(2'd3, 8'h03); wr(2'd1, 8'h0E); wr(2'd0, ctl(0, 0, 1, 0));
    step(3);
    check("R5 match flag in free mode", cmp, 1);
    wr(2'd0, ctl(0, 0, 0, 0));
    wr(2'd1, 8'hFF); wr(2'd0, ctl(0, 0, 1, 0)); step(1);
    wr(2'd0, ctl(0, 0, 0, 0));
    wr(2'd3, 8'h01);
    check("R13 write-one clears overflow", ovf, 0);
    check("R13 other flag kept", cmp, 1);
    @(negedge clk) ack_c = 1'b1;
    @(negedge clk) ack_c = 1'b0;
    check("R13 ack clears compare", cmp, 0);

    foreach (ctcs[i]) begin
      int k = ctcs[i];
      wr(2'd0, ctl(2, 0, 0, 0)); wr(2'd2, k[7:0]); wr(2'd1, 8'h00); wr(2'd3, 8'h03);
      wr(2'd0, ctl(2, 0, 1, 0));
      for (int j = 1; j <= 3 * (k + 1); j++) begin
        step(1); rd(2'd1, v);
        check($sformatf("R5 restart ocr=%0d n=%0d", k, j), v, j % (k + 1));
        if (j == k)     check("R5 flag before match", cmp, 0);
        if (j == k + 1) check("R5 flag after match", cmp, 1);
      end
    end

    wr(2'd0, ctl(2, 2, 0, 1));
    check("R7 strobe clears output", wave, 0);
    wr(2'd0, ctl(2, 1, 0, 0)); wr(2'd2, 8'd3); wr(2'd1, 8'd0); wr(2'd0, ctl(2, 1, 1, 0));
    for (int j = 1; j <= 16; j++) begin
      step(1);
      check($sformatf("R6 toggle n=%0d", j), wave, (j / 4) % 2);
    end
    wr(2'd0, ctl(2, 2, 0, 1)); wr(2'd0, ctl(2, 3, 0, 0)); wr(2'd1, 8'd0);
    wr(2'd0, ctl(2, 3, 1, 0));
    step(3); check("R6 set action before match", wave, 0);
    step(1); check("R6 set action at match", wave, 1);
    wr(2'd0, ctl(2, 2, 0, 0)); wr(2'd1, 8'd0); wr(2'd0, ctl(2, 2, 1, 0));
    step(3); check("R6 clear action before match", wave, 1);
    step(1); check("R6 clear action at match", wave, 0);
    wr(2'd0, ctl(2, 0, 0, 0));
    check("R6 disconnected output", wave, 0);

    wr(2'd0, ctl(0, 1, 0, 0)); wr(2'd1, 8'h20); wr(2'd3, 8'h03);
    wr(2'd0, ctl(0, 1, 0, 1));
    check("R7 strobe toggles output", wave, 1);
    check("R7 strobe sets no flag", cmp, 0);
    rd(2'd1, v); check("R7 strobe keeps counter", v, 8'h20);
    rd(2'd0, v); check("R2 strobe bit reads zero", v, ctl(0, 1, 0, 0));
    wr(2'd0, ctl(3, 2, 0, 1));
    check("R7 strobe ignored in PWM", wave, 1);

    wr(2'd0, ctl(2, 2, 0, 1)); wr(2'd0, ctl(2, 3, 0, 0)); wr(2'd2, 8'd5);
    wr(2'd3, 8'h03); wr(2'd1, 8'd5); wr(2'd0, ctl(2, 3, 1, 0));
    step(1); rd(2'd1, v);
    check("R8 no restart after counter write", v, 6);
    check("R8 no flag after counter write", cmp, 0);
    check("R8 no output action after counter write", wave, 0);

    for (int com = 2; com <= 3; com++) begin
      foreach (fval[i]) begin
        wr(2'd0, ctl(3, com, 1, 0)); wr(2'd2, fval[i][7:0]); step(600);
        h = 0;
        repeat (256) begin step(1); h += int'(wave); end
        check($sformatf("R9 duty action=%0d ocr=%0d", com, fval[i]), h,
              (com == 2) ? fval[i] + 1 : 255 - fval[i]);
      end
    end
    wr(2'd0, ctl(3, 1, 1, 0)); step(300);
    h = 0;
    repeat (256) begin step(1); h += int'(wave); end
    check("R9 reserved action keeps output low", h, 0);

    wr(2'd0, ctl(3, 2, 1, 0)); wr(2'd2, 8'hFF); step(300);
    wr(2'd0, ctl(3, 2, 0, 0)); wr(2'd1, 8'h10); wr(2'd2, 8'h00);
    rd(2'd2, v); check("R10 compare reads back at once", v, 0);
    wr(2'd0, ctl(3, 2, 1, 0));
    h = 0;
    for (int j = 1; j <= 239; j++) begin step(1); h += int'(wave); end
    check("R10 old compare kept until wrap", h, 239);
    step(2);
    check("R10 new compare used after wrap", wave, 0);

    wr(2'd0, ctl(0, 0, 0, 0)); wr(2'd0, ctl(1, 0, 0, 0)); wr(2'd1, 8'd2);
    wr(2'd3, 8'h03); wr(2'd0, ctl(1, 0, 1, 0));
    step(253); rd(2'd1, v); check("R11 reaches top", v, 255);
    step(1);   rd(2'd1, v); check("R11 turns down", v, 254);
    step(254); rd(2'd1, v); check("R11 reaches bottom", v, 0);
    check("R11 no overflow at bottom arrival", ovf, 0);
    step(1);   rd(2'd1, v); check("R11 turns up", v, 1);
    check("R11 overflow leaving bottom", ovf, 1);

    for (int com = 2; com <= 3; com++) begin
      foreach (pval[i]) begin
        wr(2'd0, ctl(1, com, 1, 0)); wr(2'd2, pval[i][7:0]); step(1100);
        h = 0;
        repeat (510) begin step(1); h += int'(wave); end
        check($sformatf("R12 duty action=%0d ocr=%0d", com, pval[i]), h,
              (com == 2) ? 2 * pval[i] : 510 - 2 * pval[i]);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule